// File: doc/BRIEF.md
# Regime-filtered translation cache flush engine

This block holds a small, fully associative cache of translation entries. Each entry carries tags for its translation regime, VMID, ASID, a global flag, its stage and its walk level. A system-operation front end watches a decoded instruction bundle. When the bundle names the "invalidate everything for the EL1&0 regime" operation, the front end checks the current exception level. It then does one of three things: it clears the selected regime's entries in a single cycle, it traps the operation to EL2, or it reports it as undefined.

The sweep picks entries by regime alone. The security-state select input chooses between the Secure and Non-secure EL1&0 regimes. VMID, ASID, the global flag, the stage and the level play no part in the choice, so every entry of the chosen regime goes, whatever its other tags. Entries for the EL2 and EL3 regimes and for the other EL1&0 regime stay. The flush affects only this instance. The fill port writes entries. A combinational lookup port reports hits, so the cache contents can be observed.

Top module: `tlb_regime_flush`

## Requirements
- R1: After reset, no entry is valid and `undef_o`, `trap_o` and `done_o` are low.
- R2: The operation is recognised only when op0=01, op1=100, CRn=1000, CRm=0111 and op2=100 (binary). Any other field combination has no effect: no output pulse and no entry change. The `cmd_rt` field never affects the result.
- R3: A recognised operation at exception level 0 (`cur_el`=0) raises `undef_o` and leaves every entry intact.
- R4: At `cur_el`=1, a recognised operation raises `trap_o` with `trap_ec`=0x18 when `el2_en` and `nv_bit` are both 1. Otherwise it raises `undef_o`. In both cases no entry changes.
- R5: At `cur_el`=2 or 3, a recognised operation performs the sweep, and `done_o` is high for the single cycle after the command cycle.
- R6: Regime codes are 0 = Secure EL1&0, 1 = Non-secure EL1&0, 2 = EL2 and 3 = EL3. With `ns_sel`=0 the sweep removes regime-0 entries; with `ns_sel`=1 it removes regime-1 entries.
- R7: Within the chosen regime, entries are removed whatever their VMID, ASID, global flag, stage or level.
- R8: Entries of every other regime survive the sweep.
- R9: A fill presented in the same cycle as a sweep is ignored.
- R10: `look_hit` is high when a valid entry has a matching regime, VMID and page, and is either global or has a matching ASID.
- R11: `undef_o`, `trap_o` and `done_o` are registered, last exactly one cycle per command, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | System-operation bundle is present this cycle |
| cmd_op0 | input | 2 | op0 field |
| cmd_op1 | input | 3 | op1 field |
| cmd_crn | input | 4 | CRn field |
| cmd_crm | input | 4 | CRm field |
| cmd_op2 | input | 3 | op2 field |
| cmd_rt | input | 5 | Register operand field (ignored) |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | EL2 is enabled |
| nv_bit | input | 1 | Nested-virtualization control |
| ns_sel | input | 1 | Security-state select (0 Secure, 1 Non-secure) |
| fill_valid | input | 1 | Write an entry |
| fill_idx | input | 4 | Entry slot to write |
| fill_regime | input | 2 | Regime tag of new entry |
| fill_vmid | input | 8 | VMID tag |
| fill_asid | input | 8 | ASID tag |
| fill_global | input | 1 | Global flag |
| fill_stage | input | 1 | Stage (0 stage 1, 1 stage 2) |
| fill_level | input | 2 | Walk level |
| fill_page | input | 20 | Page number |
| look_regime | input | 2 | Lookup regime |
| look_vmid | input | 8 | Lookup VMID |
| look_asid | input | 8 | Lookup ASID |
| look_page | input | 20 | Lookup page |
| look_hit | output | 1 | Lookup matched a valid entry |
| undef_o | output | 1 | Undefined-instruction pulse |
| trap_o | output | 1 | Trap-to-EL2 pulse |
| trap_ec | output | 6 | Syndrome class for the trap |
| done_o | output | 1 | Sweep completed pulse |

## Verification
The bench fills slots with entries from all four regimes, mixing global and non-global entries, both stages, several levels and several VMIDs. It then runs sweeps with each `ns_sel` value. A regime decode that is off by one would wipe EL2 or EL3 entries. A match that still compares VMID or ASID would leave some target entries alive. The bench issues the operation at EL0 and at EL1 with every trap condition, and issues a near-miss encoding at EL2. A broken privilege gate would then flush, or pulse the wrong flag or syndrome. A fill that arrives together with a sweep must not land, and a design that lets it through leaves a hit behind.

// File: rtl/tlbrf_pkg.sv
// Shared widths, tags and encodings for the regime-filtered flush engine.
package tlbrf_pkg;
    parameter int VMID_W = 8;
    parameter int ASID_W = 8;
    parameter int PAGE_W = 20;
    parameter int EC_W   = 6;
    parameter logic [EC_W-1:0] EC_SYSOP_TRAP = 6'h18;

    typedef enum logic [1:0] {
        RG_S_EL10  = 2'd0,
        RG_NS_EL10 = 2'd1,
        RG_EL2     = 2'd2,
        RG_EL3     = 2'd3
    } regime_e;

    typedef struct packed {
        regime_e           regime;
        logic [VMID_W-1:0] vmid;
        logic [ASID_W-1:0] asid;
        logic              is_global;
        logic              stage2;
        logic [1:0]        level;
        logic [PAGE_W-1:0] page;
    } entry_t;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
        logic [4:0] rt;
    } sysop_t;
endpackage

// File: rtl/tlbrf_gate.sv
// Privilege gate: recognises the flush encoding and decides between
// performing the sweep, trapping to EL2 or flagging undefined.
// Assumes cur_el holds the numeric exception level. The sweep request is
// combinational; the fault flags are registered one-cycle pulses.
module tlbrf_gate
    import tlbrf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  sysop_t               op,
    input  logic [1:0]           cur_el,
    input  logic                 el2_en,
    input  logic                 nv_bit,
    output logic                 sweep,
    output logic                 undef_o,
    output logic                 trap_o,
    output logic [EC_W-1:0]      trap_ec
);
    logic enc_ok;
    logic go;
    logic trap_n;
    logic undef_n;

    // Purpose: match the fixed field pattern; rt is deliberately not compared.
    always_comb begin
        enc_ok = (op.op0 == 2'b01) && (op.op1 == 3'b100) && (op.crn == 4'b1000)
              && (op.crm == 4'b0111) && (op.op2 == 3'b100);
        go     = cmd_valid && enc_ok;
    end

    // Purpose: split a recognised command into execute, trap or undefined.
    always_comb begin
        sweep   = go && cur_el[1];
        trap_n  = go && (cur_el == 2'd1) && el2_en && nv_bit;
        undef_n = go && !cur_el[1] && !trap_n;
    end

    // Purpose: register the fault pulses and the syndrome class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_o <= 1'b0;
            trap_o  <= 1'b0;
            trap_ec <= '0;
        end else begin
            undef_o <= undef_n;
            trap_o  <= trap_n;
            trap_ec <= trap_n ? EC_SYSOP_TRAP : '0;
        end
    end

    // R11: fault flags are exclusive
    a_r11_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_o && trap_o));
    // R4: a trap always carries the system-operation syndrome class
    a_r4_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_ec == EC_SYSOP_TRAP));
    // R3: a fault flag follows a command cycle that did not sweep
    a_r3_fault_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || trap_o) |-> ($past(cmd_valid) && !$past(sweep)));
endmodule

// File: rtl/tlbrf_array.sv
// Fully associative entry store with single-cycle regime sweep.
// Assumes the gate raises sweep for one cycle per accepted command; a fill
// in that cycle is dropped. Lookup is combinational over all slots.
module tlbrf_array
    import tlbrf_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep,
    input  logic              ns_sel,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  entry_t            fill_ent,
    input  regime_e           look_regime,
    input  logic [VMID_W-1:0] look_vmid,
    input  logic [ASID_W-1:0] look_asid,
    input  logic [PAGE_W-1:0] look_page,
    output logic              look_hit,
    output logic              done_o
);
    entry_t             ent_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] tgt_mask;
    logic [ENTRIES-1:0] hit_vec;
    regime_e            target;

    // Purpose: choose which EL1&0 regime the sweep removes.
    always_comb target = ns_sel ? RG_NS_EL10 : RG_S_EL10;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Purpose: per-slot sweep selection and lookup comparison.
        always_comb begin
            tgt_mask[g] = (ent_q[g].regime == target);
            hit_vec[g]  = valid_q[g] && (ent_q[g].regime == look_regime)
                       && (ent_q[g].vmid == look_vmid) && (ent_q[g].page == look_page)
                       && (ent_q[g].is_global || (ent_q[g].asid == look_asid));
        end
    end

    // Purpose: reduce slot hits into the lookup result.
    always_comb look_hit = |hit_vec;

    // Purpose: valid bits, cleared by reset or by the sweep, set by fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (sweep) begin
            valid_q <= valid_q & ~tgt_mask;
        end else if (fill_valid) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    // Purpose: entry payload storage, written only by non-sweep fills.
    always_ff @(posedge clk) begin
        if (!sweep && fill_valid && rst_n) begin
            ent_q[fill_idx] <= fill_ent;
        end
    end

    // Purpose: completion pulse one cycle after the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= sweep;
    end

    // R6: no entry of the swept regime remains valid
    a_r6_targets_gone: assert property (@(posedge clk) disable iff (!rst_n)
        sweep |=> ((valid_q & $past(tgt_mask)) == '0));
    // R8: entries outside the swept regime keep their valid bits
    a_r8_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sweep |=> ((valid_q & ~$past(tgt_mask)) == ($past(valid_q) & ~$past(tgt_mask))));
    // R9: a fill alongside a sweep sets no valid bit
    a_r9_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep && fill_valid) |=> ((valid_q & ~$past(valid_q)) == '0));
    // R5: completion only follows a sweep
    a_r5_done_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sweep));
endmodule

// File: rtl/tlb_regime_flush.sv
// Top: ties the privilege gate to the entry store. Port fields arrive as
// plain vectors and are packed into the shared types here.
module tlb_regime_flush
    import tlbrf_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op0,
    input  logic [2:0]        cmd_op1,
    input  logic [3:0]        cmd_crn,
    input  logic [3:0]        cmd_crm,
    input  logic [2:0]        cmd_op2,
    input  logic [4:0]        cmd_rt,
    input  logic [1:0]        cur_el,
    input  logic              el2_en,
    input  logic              nv_bit,
    input  logic              ns_sel,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [1:0]        fill_regime,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic              fill_stage,
    input  logic [1:0]        fill_level,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic [1:0]        look_regime,
    input  logic [VMID_W-1:0] look_vmid,
    input  logic [ASID_W-1:0] look_asid,
    input  logic [PAGE_W-1:0] look_page,
    output logic              look_hit,
    output logic              undef_o,
    output logic              trap_o,
    output logic [EC_W-1:0]   trap_ec,
    output logic              done_o
);
    sysop_t op;
    entry_t fill_ent;
    logic   sweep;

    // Purpose: pack the port fields into shared structures.
    always_comb begin
        op       = '{op0: cmd_op0, op1: cmd_op1, crn: cmd_crn, crm: cmd_crm,
                     op2: cmd_op2, rt: cmd_rt};
        fill_ent = '{regime: regime_e'(fill_regime), vmid: fill_vmid, asid: fill_asid,
                     is_global: fill_global, stage2: fill_stage, level: fill_level,
                     page: fill_page};
    end

    tlbrf_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .cur_el    (cur_el),
        .el2_en    (el2_en),
        .nv_bit    (nv_bit),
        .sweep     (sweep),
        .undef_o   (undef_o),
        .trap_o    (trap_o),
        .trap_ec   (trap_ec)
    );

    tlbrf_array #(.ENTRIES(ENTRIES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .sweep       (sweep),
        .ns_sel      (ns_sel),
        .fill_valid  (fill_valid),
        .fill_idx    (fill_idx),
        .fill_ent    (fill_ent),
        .look_regime (regime_e'(look_regime)),
        .look_vmid   (look_vmid),
        .look_asid   (look_asid),
        .look_page   (look_page),
        .look_hit    (look_hit),
        .done_o      (done_o)
    );

    // R11: a completion never coincides with a fault flag
    a_r11_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(undef_o || trap_o));
endmodule

// File: tb/tlb_regime_flush_tb_top.sv
module tlb_regime_flush_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op0 = '0;
    logic [2:0] cmd_op1 = '0;
    logic [3:0] cmd_crn = '0, cmd_crm = '0;
    logic [2:0] cmd_op2 = '0;
    logic [4:0] cmd_rt = '0;
    logic [1:0] cur_el = '0;
    logic el2_en = 1'b0, nv_bit = 1'b0, ns_sel = 1'b0;
    logic fill_valid = 1'b0;
    logic [3:0] fill_idx = '0;
    logic [1:0] fill_regime = '0;
    logic [7:0] fill_vmid = '0, fill_asid = '0;
    logic fill_global = 1'b0, fill_stage = 1'b0;
    logic [1:0] fill_level = '0;
    logic [19:0] fill_page = '0;
    logic [1:0] look_regime = '0;
    logic [7:0] look_vmid = '0, look_asid = '0;
    logic [19:0] look_page = '0;
    logic look_hit, undef_o, trap_o, done_o;
    logic [5:0] trap_ec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic u; logic t; logic d; logic [5:0] ec; string req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    tlb_regime_flush dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_op0(cmd_op0), .cmd_op1(cmd_op1), .cmd_crn(cmd_crn), .cmd_crm(cmd_crm),
        .cmd_op2(cmd_op2), .cmd_rt(cmd_rt), .cur_el(cur_el), .el2_en(el2_en),
        .nv_bit(nv_bit), .ns_sel(ns_sel), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_regime(fill_regime), .fill_vmid(fill_vmid), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_stage(fill_stage), .fill_level(fill_level),
        .fill_page(fill_page), .look_regime(look_regime), .look_vmid(look_vmid),
        .look_asid(look_asid), .look_page(look_page), .look_hit(look_hit),
        .undef_o(undef_o), .trap_o(trap_o), .trap_ec(trap_ec), .done_o(done_o)
    );

    // Monitor: pops the expected pulse set each cycle, or expects silence.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (undef_o !== e.u || trap_o !== e.t || done_o !== e.d ||
                    (e.t && trap_ec !== e.ec)) begin
                    errors++;
                    $display("FAIL %s: u/t/d/ec got %b%b%b/%h exp %b%b%b/%h",
                             e.req, undef_o, trap_o, done_o, trap_ec, e.u, e.t, e.d, e.ec);
                end
            end else if (undef_o || trap_o || done_o) begin
                checks++;
                errors++;
                $display("FAIL R11: stray pulse u/t/d got %b%b%b exp 000",
                         undef_o, trap_o, done_o);
            end
        end
    end

    task automatic fill(input logic [3:0] idx, input logic [1:0] rg, input logic [7:0] vm,
                        input logic [7:0] as, input logic gl, input logic st,
                        input logic [1:0] lv, input logic [19:0] pg);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = idx; fill_regime = rg; fill_vmid = vm;
        fill_asid = as; fill_global = gl; fill_stage = st; fill_level = lv; fill_page = pg;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Driver: issues one command and pushes the expected pulses.
    task automatic issue(input logic [2:0] op2, input logic [1:0] el, input logic e2,
                         input logic nv, input logic ns, input logic [4:0] rt,
                         input logic with_fill, input logic eu, input logic et,
                         input logic ed, input string req);
        exp_t e;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op0 = 2'b01; cmd_op1 = 3'b100; cmd_crn = 4'b1000;
        cmd_crm = 4'b0111; cmd_op2 = op2; cmd_rt = rt; cur_el = el;
        el2_en = e2; nv_bit = nv; ns_sel = ns;
        if (with_fill) begin
            fill_valid = 1'b1; fill_idx = 4'd6; fill_regime = 2'd2; fill_vmid = 8'd7;
            fill_asid = 8'd0; fill_global = 1'b1; fill_stage = 1'b0; fill_level = 2'd0;
            fill_page = 20'h500;
        end
        @(posedge clk);
        e.u = eu; e.t = et; e.d = ed; e.ec = 6'h18; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0; fill_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_hit(input logic [1:0] rg, input logic [7:0] vm, input logic [7:0] as,
                             input logic [19:0] pg, input logic exp, input string req);
        @(negedge clk);
        look_regime = rg; look_vmid = vm; look_asid = as; look_page = pg;
        #1;
        checks++;
        if (look_hit !== exp) begin
            errors++;
            $display("FAIL %s: hit page %h got %b exp %b", req, pg, look_hit, exp);
        end
    endtask

    // Checks all six seeded entries against the expected presence pattern.
    task automatic check_all(input logic [5:0] pres, input string req);
        check_hit(2'd0, 8'd1, 8'd5, 20'h100, pres[0], req);
        check_hit(2'd0, 8'd2, 8'd9, 20'h101, pres[1], req);
        check_hit(2'd1, 8'd1, 8'd5, 20'h200, pres[2], req);
        check_hit(2'd1, 8'd9, 8'd3, 20'h201, pres[3], req);
        check_hit(2'd2, 8'd0, 8'd0, 20'h300, pres[4], req);
        check_hit(2'd3, 8'd0, 8'd0, 20'h400, pres[5], req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (undef_o || trap_o || done_o) begin
            errors++;
            $display("FAIL R1: outputs after reset got %b%b%b exp 000", undef_o, trap_o, done_o);
        end
        check_hit(2'd0, 8'd0, 8'd0, 20'h0, 1'b0, "R1");

        // Seed: two Secure EL1&0, two Non-secure EL1&0, one EL2, one EL3
        fill(4'd0, 2'd0, 8'd1, 8'd5, 1'b0, 1'b0, 2'd3, 20'h100);
        fill(4'd1, 2'd0, 8'd2, 8'd4, 1'b1, 1'b1, 2'd1, 20'h101);
        fill(4'd2, 2'd1, 8'd1, 8'd5, 1'b0, 1'b0, 2'd2, 20'h200);
        fill(4'd3, 2'd1, 8'd9, 8'd8, 1'b1, 1'b1, 2'd0, 20'h201);
        fill(4'd4, 2'd2, 8'd0, 8'd0, 1'b1, 1'b0, 2'd3, 20'h300);
        fill(4'd5, 2'd3, 8'd0, 8'd0, 1'b1, 1'b0, 2'd3, 20'h400);
        check_all(6'b111111, "R10");
        // R10: wrong ASID on a non-global entry misses
        check_hit(2'd0, 8'd1, 8'd6, 20'h100, 1'b0, "R10");

        // R3: EL0 is undefined, no change
        issue(3'b100, 2'd0, 1'b1, 1'b1, 1'b1, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        check_all(6'b111111, "R3");
        // R4: EL1 without nested virtualization is undefined
        issue(3'b100, 2'd1, 1'b1, 1'b0, 1'b1, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        issue(3'b100, 2'd1, 1'b0, 1'b1, 1'b1, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        // R4: EL1 with EL2 enabled and nested virtualization traps
        issue(3'b100, 2'd1, 1'b1, 1'b1, 1'b1, 5'd31, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        check_all(6'b111111, "R4");
        // R2: near-miss encoding at EL2 does nothing
        issue(3'b101, 2'd2, 1'b0, 1'b0, 1'b1, 5'd31, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        check_all(6'b111111, "R2");

        // R5 R6 R7 R9: EL2 sweep of Non-secure EL1&0, odd rt, fill alongside
        issue(3'b100, 2'd2, 1'b0, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        check_all(6'b110011, "R7");
        check_hit(2'd2, 8'd7, 8'd0, 20'h500, 1'b0, "R9");

        // R5 R6 R8: EL3 sweep of Secure EL1&0
        issue(3'b100, 2'd3, 1'b0, 1'b0, 1'b0, 5'd31, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        check_all(6'b110000, "R8");

        // R10: refill after the sweep is visible again
        fill(4'd0, 2'd0, 8'd1, 8'd5, 1'b0, 1'b0, 2'd3, 20'h100);
        check_hit(2'd0, 8'd1, 8'd5, 20'h100, 1'b1, "R10");

        repeat (3) @(negedge clk);
        // R11: every expected pulse was consumed
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R11: pending items got %0d exp 0", sb_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule